// File: doc/BRIEF.md
# Rectangular-Window Spike-Timing Plasticity Updater

This block maintains one unsigned synaptic weight and adjusts it from the relative timing of presynaptic and postsynaptic spikes. Time is divided into timesteps by a strobe input. Spikes of either kind that arrive during a timestep are held until that timestep's strobe. At the strobe the block evaluates the timestep.

For each side, a counter records how many whole timesteps have passed without a spike on that side. A spike on one side is paired with the most recent spike on the other side only if that counter is no larger than the programmed window length. Every pair inside the window has the same effect: a change of exactly one. If the presynaptic spike came first, the weight rises by one. If the postsynaptic spike came first, the weight falls by one. The weight stops at its bounds and never wraps.

The block is used next to a neuron array's timestep sequencer. The sequencer drives the strobe once per simulated timestep, and the spike lines come from the neuron logic. The weight output and its change pulse are plain control pins with no back-pressure, because the block produces at most one result per timestep and the result persists on `weight_o`.

Top module: `stdp_rect_updater`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `weight_o` equals INIT_W (default 128) and `upd_valid_o` is 0. Both elapsed counters start outside every window, so the first spike of either kind after reset causes no update.
- R2: At a strobe where a postsynaptic spike is seen and no presynaptic spike is seen, the weight rises by one if the presynaptic counter is at most the effective window. `upd_dir_o`=1 marks this rise.
- R3: At a strobe where a presynaptic spike is seen and no postsynaptic spike is seen, the weight falls by one if the postsynaptic counter is at most the effective window. `upd_dir_o`=0 marks this fall.
- R4: The window is rectangular. The counter holds d−1 for two spikes d timesteps apart, so the pair updates if and only if d−1 ≤ window, and the change is always exactly one.
- R5: When both spike kinds are seen in the same timestep, the weight does not change, no pulse is given, and both counters restart at 0. A presynaptic spike alone in the next timestep therefore causes a fall.
- R6: The weight saturates. It never rises above 255 and never falls below 0. A request that would cross a bound changes nothing and gives no pulse.
- R7: `weight_o`, `upd_valid_o` and `upd_dir_o` are registered at the strobe edge. `upd_valid_o` is high for exactly the one cycle after a strobe that changed the weight, and at most one change occurs per timestep.
- R8: A spike pulse in any cycle of a timestep, including the strobe cycle itself, counts for that timestep. Several pulses of the same kind in one timestep count as one.
- R9: A window input of all ones (15 at the default width) is treated as 14.
- R10: Each counter stops one past the window. A long silence never brings a stale spike back into the window by wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Timestep strobe; the timestep is closed at this cycle's edge |
| pre_spike_i | input | 1 | Presynaptic spike pulse |
| post_spike_i | input | 1 | Postsynaptic spike pulse |
| win_len_i | input | CW (4) | Window length in timesteps |
| weight_o | output | WW (8) | Current unsigned weight |
| upd_valid_o | output | 1 | One-cycle pulse when the weight changed |
| upd_dir_o | output | 1 | Direction of the last change: 1 = rise, 0 = fall |

## Verification
Every result of this block is due on the first clock edge after the strobe cycle that closes a timestep. The bench drives the strobe and that timestep's spikes at a falling edge. It then samples the weight, the pulse and the direction at the next falling edge, which is exactly one register stage later. One further falling edge with no strobe confirms that the pulse has dropped.

Spikes injected in the middle of a timestep are folded into the bench's reference model. They take effect only at the following strobe, so the checks never expect an output to move before that strobe's edge. Expected values come from a model that keeps its own elapsed-timestep counts and a saturating weight. Random spike patterns and window changes are mixed with directed cases at the window edge, the same-timestep case, the window clamp and both saturation bounds.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_POT  = 2'd1,
    ACT_DEP  = 2'd2
  } stdp_act_e;
endpackage

// File: rtl/stdp_spike_hold.sv
// Holds a spike seen during the current timestep until the strobe closes it.
module stdp_spike_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic spike_i,
  output logic seen_o
);
  logic pend_q;

  assign seen_o = pend_q | spike_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (step_i) pend_q <= 1'b0;
    else             pend_q <= seen_o;
  end
endmodule

// File: rtl/stdp_since_ctr.sv
// Counts timesteps since this side's last spike; holds once past the window.
module stdp_since_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          own_i,
  input  logic [CW-1:0] win_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CMAX;
    end else if (step_i) begin
      if (own_i)               cnt_q <= '0;
      else if (cnt_q <= win_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stdp_pair_judge.sv
// Decides the action for the closing timestep from the held spikes and counters.
module stdp_pair_judge
  import stdp_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          step_i,
  input  logic          pre_seen_i,
  input  logic          post_seen_i,
  input  logic [CW-1:0] pre_cnt_i,
  input  logic [CW-1:0] post_cnt_i,
  input  logic [CW-1:0] win_i,
  output stdp_act_e     act_o
);
  logic causal_ok, anti_ok;

  assign causal_ok = post_seen_i && !pre_seen_i && (pre_cnt_i <= win_i);
  assign anti_ok   = pre_seen_i && !post_seen_i && (post_cnt_i <= win_i);

  always_comb begin
    act_o = ACT_NONE;
    if (step_i) begin
      if (causal_ok)    act_o = ACT_POT;
      else if (anti_ok) act_o = ACT_DEP;
    end
  end
endmodule

// File: rtl/stdp_weight_reg.sv
// Saturating weight register with a change pulse and direction flag.
module stdp_weight_reg
  import stdp_pkg::*;
#(
  parameter int          WW     = 8,
  parameter int unsigned INIT_W = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stdp_act_e     act_i,
  output logic [WW-1:0] weight_o,
  output logic          valid_o,
  output logic          dir_o
);
  localparam logic [WW-1:0] WMAX   = {WW{1'b1}};
  localparam logic [WW-1:0] INIT_V = INIT_W[WW-1:0];

  logic [WW-1:0] w_q;
  assign weight_o = w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q     <= INIT_V;
      valid_o <= 1'b0;
      dir_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (act_i)
        ACT_POT: if (w_q != WMAX) begin
          w_q     <= w_q + 1'b1;
          valid_o <= 1'b1;
          dir_o   <= 1'b1;
        end
        ACT_DEP: if (w_q != '0) begin
          w_q     <= w_q - 1'b1;
          valid_o <= 1'b1;
          dir_o   <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stdp_rect_updater.sv
module stdp_rect_updater
  import stdp_pkg::*;
#(
  parameter int          CW     = 4,
  parameter int          WW     = 8,
  parameter int unsigned INIT_W = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          pre_spike_i,
  input  logic          post_spike_i,
  input  logic [CW-1:0] win_len_i,
  output logic [WW-1:0] weight_o,
  output logic          upd_valid_o,
  output logic          upd_dir_o
);
  localparam int              NSIDE = 2;  // index 0 = pre, 1 = post
  localparam logic [CW-1:0]   CMAX  = {CW{1'b1}};

  logic [CW-1:0] win_eff;
  logic [NSIDE-1:0] spike_in, seen;
  logic [CW-1:0] cnt [NSIDE];
  stdp_act_e act;

  // An all-ones window would collide with the "outside" counter value.
  assign win_eff  = (win_len_i == CMAX) ? CMAX - 1'b1 : win_len_i;
  assign spike_in = {post_spike_i, pre_spike_i};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    stdp_spike_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step_i),
      .spike_i (spike_in[s]),
      .seen_o  (seen[s])
    );
    stdp_since_ctr #(.CW(CW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .own_i  (seen[s]),
      .win_i  (win_eff),
      .cnt_o  (cnt[s])
    );
  end

  stdp_pair_judge #(.CW(CW)) u_judge (
    .step_i      (step_i),
    .pre_seen_i  (seen[0]),
    .post_seen_i (seen[1]),
    .pre_cnt_i   (cnt[0]),
    .post_cnt_i  (cnt[1]),
    .win_i       (win_eff),
    .act_o       (act)
  );

  stdp_weight_reg #(.WW(WW), .INIT_W(INIT_W)) u_wreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act),
    .weight_o (weight_o),
    .valid_o  (upd_valid_o),
    .dir_o    (upd_dir_o)
  );
endmodule

// File: rtl/stdp_rect_checker.sv
module stdp_rect_checker #(
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_i,
  input logic          pre_spike_i,
  input logic          post_spike_i,
  input logic [WW-1:0] weight_o,
  input logic          upd_valid_o,
  input logic          upd_dir_o
);
  // R7: a change pulse only follows a strobe
  a_r7_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |-> $past(step_i));

  // R7: the weight never moves without the pulse
  a_r7_move_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(weight_o) |-> upd_valid_o);

  // R2 and R6: a rise is exactly one and never wraps past the top
  a_r2_pot_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_o && upd_dir_o) |->
      ({1'b0, weight_o} == {1'b0, $past(weight_o)} + 1'b1));

  // R3 and R6: a fall is exactly one and never wraps below zero
  a_r3_dep_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_o && !upd_dir_o) |->
      ({1'b0, $past(weight_o)} == {1'b0, weight_o} + 1'b1));

  // R5: both spikes at the closing strobe give no change
  a_r5_same_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && pre_spike_i && post_spike_i) |=> (!upd_valid_o && $stable(weight_o)));
endmodule

bind stdp_rect_updater stdp_rect_checker #(.WW(WW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_i       (step_i),
  .pre_spike_i  (pre_spike_i),
  .post_spike_i (post_spike_i),
  .weight_o     (weight_o),
  .upd_valid_o  (upd_valid_o),
  .upd_dir_o    (upd_dir_o)
);

// File: tb/sim_stdp_rect_updater.sv
module sim_stdp_rect_updater;
  localparam int CW = 4;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, pre_i = 1'b0, post_i = 1'b0;
  logic [CW-1:0] win = 4'd2;
  logic [WW-1:0] weight_o;
  logic upd_valid_o, upd_dir_o;

  int n_chk = 0, n_fail = 0;
  int m_w = 128;
  int m_pre = 15, m_post = 15;
  bit m_pp = 0, m_pq = 0;
  bit m_dir = 0;

  always #5 clk = ~clk;

  stdp_rect_updater #(.CW(CW), .WW(WW), .INIT_W(128)) u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .pre_spike_i(pre_i), .post_spike_i(post_i), .win_len_i(win),
    .weight_o(weight_o), .upd_valid_o(upd_valid_o), .upd_dir_o(upd_dir_o)
  );

  function automatic int eff_win(input int w);
    return (w == 15) ? 14 : w;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // mid-timestep spike pulse (no strobe)
  task automatic spike_mid(input bit p, input bit q);
    @(negedge clk);
    pre_i = p; post_i = q;
    m_pp |= p; m_pq |= q;
    @(negedge clk);
    pre_i = 0; post_i = 0;
  endtask

  // close a timestep with the given spikes on the strobe cycle, then check
  task automatic tstep(input bit p, input bit q, input string tag);
    bit ep, eq, exp_v;
    int w;
    ep = p | m_pp; eq = q | m_pq;
    m_pp = 0; m_pq = 0;
    w = eff_win(int'(win));
    exp_v = 0;
    if (eq && !ep && m_pre <= w) begin
      if (m_w < 255) begin m_w++; exp_v = 1; m_dir = 1; end
    end else if (ep && !eq && m_post <= w) begin
      if (m_w > 0) begin m_w--; exp_v = 1; m_dir = 0; end
    end
    if (ep) m_pre = 0; else if (m_pre <= w) m_pre++;
    if (eq) m_post = 0; else if (m_post <= w) m_post++;
    @(negedge clk);
    step_i = 1; pre_i = p; post_i = q;
    @(negedge clk);
    step_i = 0; pre_i = 0; post_i = 0;
    chk(int'(weight_o), m_w, {tag, " weight"});
    chk(int'(upd_valid_o), int'(exp_v), {tag, " valid"});
    if (exp_v) chk(int'(upd_dir_o), int'(m_dir), {tag, " dir"});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tstep(0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(weight_o), 128, "R1 weight in reset");
    chk(int'(upd_valid_o), 0, "R1 valid in reset");
    rst_n = 1;
    @(negedge clk);
    chk(int'(weight_o), 128, "R1 weight after reset");
    chk(int'(upd_valid_o), 0, "R1 valid after reset");
    tstep(1, 0, "R1 first pre");
    tstep(0, 1, "R2 causal pair");
    @(negedge clk);
    chk(int'(upd_valid_o), 0, "R7 pulse one cycle");
    tstep(1, 0, "R3 anticausal pair");
    // R4 window edges, W=2
    idle(5, "R4 idle");
    tstep(1, 0, "R4 lone pre");
    idle(2, "R4 gap");
    tstep(0, 1, "R4 d=W+1 inside");
    idle(5, "R4 idle");
    tstep(1, 0, "R4 lone pre");
    idle(3, "R4 gap");
    tstep(0, 1, "R4 d=W+2 outside");
    // R5 same timestep
    tstep(1, 1, "R5 both spikes");
    tstep(1, 0, "R5 counters restarted");
    // R8 held and repeated spikes
    idle(5, "R8 idle");
    spike_mid(1, 0);
    spike_mid(1, 0);
    tstep(0, 0, "R8 held pre");
    spike_mid(0, 1);
    tstep(0, 1, "R8 post twice");
    // R9 window clamp
    win = 4'd15;
    idle(20, "R9 idle");
    tstep(1, 0, "R9 lone pre");
    idle(14, "R9 gap");
    tstep(0, 1, "R9 d=15 inside");
    idle(20, "R9 idle");
    tstep(1, 0, "R9 lone pre");
    idle(15, "R9 gap");
    tstep(0, 1, "R9 d=16 outside");
    // R10 no wrap over long silence
    win = 4'd3;
    idle(8, "R10 idle");
    tstep(1, 0, "R10 lone pre");
    idle(20, "R10 long gap");
    tstep(0, 1, "R10 stale pre");
    // R6 saturation
    win = 4'd0;
    idle(2, "R6 idle");
    while (m_w < 255) begin
      tstep(1, 0, "R6 up pre"); tstep(0, 1, "R6 up post"); idle(1, "R6 idle");
    end
    repeat (3) begin
      tstep(1, 0, "R6 top pre"); tstep(0, 1, "R6 top hold"); idle(1, "R6 idle");
    end
    chk(int'(weight_o), 255, "R6 upper bound");
    while (m_w > 0) begin
      tstep(0, 1, "R6 dn post"); tstep(1, 0, "R6 dn pre"); idle(1, "R6 idle");
    end
    repeat (3) begin
      tstep(0, 1, "R6 bottom post"); tstep(1, 0, "R6 bottom hold"); idle(1, "R6 idle");
    end
    chk(int'(weight_o), 0, "R6 lower bound");
    // random mix
    for (int i = 0; i < 800; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) win = CW'($urandom_range(0, 15));
      if (r >= 90) spike_mid($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      tstep($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, "R2 R3 R4 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule